// File: doc/BRIEF.md
# UART Channel Command Decoder

This block is the control front end of one UART channel. The processor writes a command byte that carries three independent fields. The low two bits govern the receiver. The next two bits govern the transmitter. The high nibble selects one miscellaneous action. The block turns each write into held enable levels, a held active-low RTS level, and single-cycle strobes. These strobes flush the FIFOs, clear status flags and request the start or end of a break.

The block also holds the two mode registers behind a single address. A hidden pointer decides which of the two the next access reaches. After reset, or after the pointer-reset command, the next access goes to the first mode register. Any read or write of the first register moves the pointer to the second. Accesses to the second register leave the pointer where it is.

Every register updates on the clock edge that samples the write, so held levels and pulses appear in the cycle after the write. Read data is combinational.

Top module: `uart_cmd_decoder`

## Requirements
- R1: After reset, rx_en and tx_en are 0, rts_n is 1, mode_ptr is 0 (first mode register) and every strobe output is 0.
- R2: A write to address 1 (command) with wdata[1:0] = 01 sets rx_en, 10 clears it, and 00 or 11 leaves it unchanged.
- R3: wdata[3:2] of a command write controls tx_en with the same encoding as R2.
- R4: Miscellaneous code wdata[7:4] = 0010 pulses rx_flush and clears rx_en. This wins over a receiver enable in the same write.
- R5: Code 0011 pulses tx_flush and clears tx_en. This wins over a transmitter enable in the same write.
- R6: Code 0100 pulses err_clr, and code 0101 pulses brk_chg_clr.
- R7: Code 0110 pulses brk_start only when tx_en, after the transmitter field of the same write is applied, is 1. Otherwise the code is ignored.
- R8: Code 0111 pulses brk_stop.
- R9: Code 1000 drives rts_n to 0 and code 1001 drives it to 1. The level is held until the next such code.
- R10: Code 0000 and codes 1010 through 1111 change no output.
- R11: Code 0001 returns mode_ptr to 0. A read or write at address 0 (mode) reaches mode1_q when mode_ptr is 0 and then sets mode_ptr to 1. At mode_ptr 1 it reaches mode2_q and leaves the pointer unchanged. rdata at address 0 shows the selected mode register. At other addresses rdata is 0.
- R12: The receiver field, the transmitter field and the miscellaneous code of one write all take effect together.
- R13: Each strobe is high for exactly the one cycle after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances the mode pointer) |
| addr | input | ADDR_W | Register address: 0 mode window, 1 command |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| mode1_q | output | DATA_W | First mode register contents |
| mode2_q | output | DATA_W | Second mode register contents |
| mode_ptr | output | 1 | Mode pointer, 0 first register, 1 second |
| rx_en | output | 1 | Receiver enable level |
| tx_en | output | 1 | Transmitter enable level |
| rts_n | output | 1 | Active-low RTS level |
| rx_flush | output | 1 | Receiver reset and FIFO flush strobe |
| tx_flush | output | 1 | Transmitter reset and FIFO flush strobe |
| err_clr | output | 1 | Clear break, parity and overrun flags strobe |
| brk_chg_clr | output | 1 | Clear break-change interrupt flag strobe |
| brk_start | output | 1 | Start-break request strobe |
| brk_stop | output | 1 | Stop-break request strobe |

## Verification
The bench runs the command decoder through a chain of bytes. First each field acts alone. Then both direction fields act together, which separates a mixed-up receiver and transmitter decode. Then direction fields are paired with reset and break codes: these writes reveal whether the reset priority holds and whether the break gate sees the enable of the same write or the previous one. The 11 field and the spare nibble codes show that unused encodings do nothing. The mode-window tests alternate reads and writes around the pointer reset, so a pointer that moves on reads alone, or on writes alone, is caught.

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int MODE_ADDR = 0,
  parameter int CMD_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mode1_q,
  output logic [DATA_W-1:0] mode2_q,
  output logic              mode_ptr,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rts_n,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              err_clr,
  output logic              brk_chg_clr,
  output logic              brk_start,
  output logic              brk_stop
);
  localparam logic [3:0] OP_PTR = 4'h1, OP_RXR = 4'h2, OP_TXR = 4'h3,
                         OP_ERR = 4'h4, OP_BCH = 4'h5, OP_BON = 4'h6,
                         OP_BOFF = 4'h7, OP_RLO = 4'h8, OP_RHI = 4'h9;

  logic       cmd_wr, mode_hit, mode_acc, rx_nx, tx_nx;
  logic [3:0] op;

  assign cmd_wr   = wr_en && (addr == ADDR_W'(CMD_ADDR));
  assign mode_hit = (addr == ADDR_W'(MODE_ADDR));
  assign mode_acc = (wr_en || rd_en) && mode_hit;
  assign op       = wdata[7:4];
  assign rdata    = mode_hit ? (mode_ptr ? mode2_q : mode1_q) : '0;

  function automatic logic field_next(input logic [1:0] f, input logic cur);
    case (f)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      default: return cur;
    endcase
  endfunction

  always_comb begin
    rx_nx = rx_en;
    tx_nx = tx_en;
    if (cmd_wr) begin
      rx_nx = (op == OP_RXR) ? 1'b0 : field_next(wdata[1:0], rx_en);
      tx_nx = (op == OP_TXR) ? 1'b0 : field_next(wdata[3:2], tx_en);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en       <= 1'b0;
      tx_en       <= 1'b0;
      rts_n       <= 1'b1;
      mode_ptr    <= 1'b0;
      mode1_q     <= '0;
      mode2_q     <= '0;
      rx_flush    <= 1'b0;
      tx_flush    <= 1'b0;
      err_clr     <= 1'b0;
      brk_chg_clr <= 1'b0;
      brk_start   <= 1'b0;
      brk_stop    <= 1'b0;
    end else begin
      rx_en       <= rx_nx;
      tx_en       <= tx_nx;
      rx_flush    <= cmd_wr && op == OP_RXR;
      tx_flush    <= cmd_wr && op == OP_TXR;
      err_clr     <= cmd_wr && op == OP_ERR;
      brk_chg_clr <= cmd_wr && op == OP_BCH;
      brk_start   <= cmd_wr && op == OP_BON && tx_nx;
      brk_stop    <= cmd_wr && op == OP_BOFF;
      if (cmd_wr && op == OP_RLO) rts_n <= 1'b0;
      if (cmd_wr && op == OP_RHI) rts_n <= 1'b1;
      if (cmd_wr && op == OP_PTR) mode_ptr <= 1'b0;
      else if (mode_acc)          mode_ptr <= 1'b1;
      if (wr_en && mode_hit) begin
        if (mode_ptr) mode2_q <= wdata;
        else          mode1_q <= wdata;
      end
    end
  end
endmodule

module uart_cmd_decoder_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int MODE_ADDR = 0,
  parameter int CMD_ADDR  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] mode1_q,
  input logic              mode_ptr,
  input logic              rx_en,
  input logic              tx_en,
  input logic              rts_n,
  input logic              rx_flush,
  input logic              tx_flush,
  input logic              err_clr,
  input logic              brk_chg_clr,
  input logic              brk_start,
  input logic              brk_stop
);
  logic cmd_w, mode_w;
  assign cmd_w  = wr_en && addr == ADDR_W'(CMD_ADDR);
  assign mode_w = (wr_en || rd_en) && addr == ADDR_W'(MODE_ADDR);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_flush, tx_flush, err_clr, brk_chg_clr, brk_start, brk_stop}));
  // R4
  rx_flush_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> !rx_en);
  // R5
  tx_flush_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> !tx_en);
  // R7
  brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> tx_en && $past(wdata[7:4]) == 4'h6);
  // R13
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush || tx_flush || err_clr || brk_chg_clr || brk_start || brk_stop) |-> $past(cmd_w));
  // R9
  rts_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rts_n) |-> $past(cmd_w));
  // R11
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w && !mode_ptr) |=> mode_ptr);
  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ptr && !cmd_w) |=> mode_ptr);
  // R11
  mode1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode1_q) |-> $past(wr_en && addr == ADDR_W'(MODE_ADDR) && !mode_ptr));
endmodule

bind uart_cmd_decoder uart_cmd_decoder_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .CMD_ADDR(CMD_ADDR)
) chk_i (.*);

// File: tb/uart_cmd_decoder_tb.sv
module uart_cmd_decoder_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mode1_q, mode2_q;
  logic mode_ptr, rx_en, tx_en, rts_n, rx_flush, tx_flush, err_clr, brk_chg_clr, brk_start, brk_stop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_cmd_decoder dut_i (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .mode1_q, .mode2_q, .mode_ptr, .rx_en, .tx_en, .rts_n, .rx_flush, .tx_flush,
    .err_clr, .brk_chg_clr, .brk_start, .brk_stop);

  // {rx_en, tx_en, rts_n, rx_flush, tx_flush, err_clr, brk_chg_clr, brk_start, brk_stop}
  function automatic logic [8:0] obs();
    return {rx_en, tx_en, rts_n, rx_flush, tx_flush, err_clr, brk_chg_clr, brk_start, brk_stop};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic rd, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  localparam int NV = 21;
  localparam logic [16:0] VEC [NV] = '{
    {8'h01, 9'b1_0_1_000000},   // R2 rx enable
    {8'h04, 9'b1_1_1_000000},   // R3 tx enable
    {8'h0A, 9'b0_0_1_000000},   // R2 R3 both disable
    {8'h0F, 9'b0_0_1_000000},   // R2 R3 code 11 ignored
    {8'h05, 9'b1_1_1_000000},   // R12 both enable
    {8'h00, 9'b1_1_1_000000},   // R10 no command
    {8'h40, 9'b1_1_1_001000},   // R6 clear errors
    {8'h50, 9'b1_1_1_000100},   // R6 clear break change
    {8'h60, 9'b1_1_1_000010},   // R7 start break, tx on
    {8'h70, 9'b1_1_1_000001},   // R8 stop break
    {8'h80, 9'b1_1_0_000000},   // R9 rts low
    {8'hA0, 9'b1_1_0_000000},   // R10 spare code
    {8'hF0, 9'b1_1_0_000000},   // R10 spare code
    {8'h90, 9'b1_1_1_000000},   // R9 rts high
    {8'h21, 9'b0_1_1_100000},   // R4 reset beats enable
    {8'h34, 9'b0_0_1_010000},   // R5 reset beats enable
    {8'h60, 9'b0_0_1_000000},   // R7 ignored, tx off
    {8'h64, 9'b0_1_1_000010},   // R7 enable in same write
    {8'h68, 9'b0_0_1_000000},   // R7 disable in same write
    {8'h85, 9'b1_1_0_000000},   // R12 three fields
    {8'h2C, 9'b0_1_0_100000}    // R4 R12 with tx field 11
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1
    rst_n = 1;
    check("R1 reset state", {7'd0, obs()}, {7'd0, 9'b0_0_1_000000});
    check("R1 reset pointer", {15'd0, mode_ptr}, 16'd0);
    for (int i = 0; i < NV; i++) begin
      bus(1, 0, 2'd1, VEC[i][16:9]);
      check("R2-R12 vector", {7'd0, obs()}, {7'd0, VEC[i][8:0]});
      @(negedge clk);
      // R13
      check("R13 strobe drop", {10'd0, obs() & 9'h03F}, 16'd0);
    end
    // R11
    bus(1, 0, 2'd0, 8'h11);
    check("R11 first write to mode1", {mode1_q, mode2_q}, {8'h11, 8'h00});
    bus(1, 0, 2'd0, 8'h22);
    bus(1, 0, 2'd0, 8'h33);
    check("R11 later writes to mode2", {mode1_q, mode2_q}, {8'h11, 8'h33});
    @(negedge clk); addr = 2'd0;
    #1 check("R11 read mode2", {8'd0, rdata}, {8'd0, 8'h33});
    bus(1, 0, 2'd1, 8'h10);
    check("R11 pointer reset", {15'd0, mode_ptr}, 16'd0);
    check("R11 pointer cmd leaves levels", {7'd0, obs()}, {7'd0, 9'b0_1_0_000000});
    addr = 2'd0;
    #1 check("R11 read mode1", {8'd0, rdata}, {8'd0, 8'h11});
    bus(0, 1, 2'd0, 8'h00);
    check("R11 read advances pointer", {15'd0, mode_ptr}, 16'd1);
    bus(0, 1, 2'd0, 8'h00);
    #1 check("R11 read of mode2 holds", {7'd0, mode_ptr, rdata}, {7'd0, 1'b1, 8'h33});
    addr = 2'd1;
    #1 check("R11 rdata at command addr", {8'd0, rdata}, 16'd0);
    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R1 reset again", {6'd0, mode_ptr, obs()}, {6'd0, 1'b0, 9'b0_0_1_000000});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule